// File: doc/BRIEF.md
# Instruction Trace Pending Controller

This block holds the two status bits that drive single-instruction tracing: a live trace-enable bit and a trace-pending bit. It watches the instruction-start and instruction-complete strobes from the execution pipeline. At each instruction start it raises a one-cycle trace-fault request whenever the pending bit is set. The pending bit is cleared when that request is taken, and it is loaded again from the enable bit when the instruction completes. As a result, each traced instruction produces exactly one trace fault.

Four instruction kinds need special treatment, and the completion strobe tags each one with an event code: mode change, return from interrupt, set of the trace-enable bit by a status-bit-set instruction, and procedure call. For these, the block computes the new live bits and the bits to be written into the saved status word, so tracing is neither skipped nor repeated across them. It also holds back a reserved-opcode fault while a trace fault is due, because the trace fault outranks every other exception. The fault is raised instead when the instruction restarts.

The bits to be saved are plain combinational outputs, valid during the completion cycle. There is no data stream at the edge, so every pin is a plain control or status signal with no handshake.

Top module: `tpc_trace_ctrl`

## Requirements
- R1: After reset, the live trace-enable and trace-pending bits are both 0, and no trace request is raised.
- R2: `trace_req` is high in exactly those cycles where `inst_start` is high and the pending bit is set. That start edge clears the pending bit.
- R3: While a trace request is raised, `rsvd_fault` stays low even if `rsvd_opc` is high. The restart that follows the trace raises `rsvd_fault` if the opcode is still reserved.
- R4: Completion with event code 0 (no special event) loads the pending bit from the enable bit and leaves the enable bit unchanged.
- R5: Completion with event code 1 (mode change) clears both live bits. In that cycle `sav_t` and `sav_tp` both equal the enable bit as it was at the start of the instruction.
- R6: Completion with event code 2 (return from interrupt) sets the enable bit to `rei_t`. It sets the pending bit to the OR of the old enable bit and `rei_tp`.
- R7: Completion with event code 3 (set trace enable) sets the enable bit and loads the pending bit from the old enable bit. Tracing therefore starts with the second instruction after it.
- R8: Completion with event code 4 (call) drives `sav_t` low in that cycle, leaves the live enable bit unchanged, and loads the pending bit from it.
- R9: Event codes 5 to 7 behave exactly like code 0.
- R10: With `inst_start` low, `trace_req` stays low whatever the pending bit holds.
- R11: Outside a call or mode-change completion, `sav_t` equals the live enable bit and `sav_tp` equals the live pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_start | input | 1 | Strobe: an instruction begins this cycle |
| inst_done | input | 1 | Strobe: an instruction completes this cycle |
| evt_kind | input | 3 | Event code of the completing instruction |
| rei_t | input | 1 | Trace-enable bit from the restored status word |
| rei_tp | input | 1 | Trace-pending bit from the restored status word |
| rsvd_opc | input | 1 | The starting instruction has a reserved or privileged opcode |
| trace_req | output | 1 | One-cycle trace-fault request |
| rsvd_fault | output | 1 | Reserved-instruction fault request, after the trace check |
| t_live | output | 1 | Live trace-enable bit |
| tp_live | output | 1 | Live trace-pending bit |
| sav_t | output | 1 | Trace-enable value for the saved status word |
| sav_tp | output | 1 | Trace-pending value for the saved status word |

## Verification
Instruction runs are driven with tracing off, with tracing switched on by the set-enable event, and with tracing on in steady state. Comparing the first and second instructions after the set-enable event separates the one-instruction delay from an immediate start. Returns from interrupt are tried with every source of the pending bit: old enable only, restored pending only, and neither. This shows that the pending bit is the OR of the two and that the enable bit is taken from the restored word. A reserved opcode on a traced instruction shows that its fault is deferred to the restart and not dropped. Mode-change and call completions with tracing on separate the saved bits from the new live bits.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    EVK_NONE  = 3'd0,
    EVK_CHM   = 3'd1,
    EVK_REI   = 3'd2,
    EVK_SET_T = 3'd3,
    EVK_CALL  = 3'd4
  } evt_kind_e;

  typedef struct packed {
    logic done;
    logic chm;
    logic rei;
    logic set_t;
    logic call;
  } evt_hot_t;
endpackage

// File: rtl/tpc_evt_decode.sv
module tpc_evt_decode
  import tpc_pkg::*;
#(
  parameter int W = KIND_W
) (
  input  logic         done_i,
  input  logic [W-1:0] kind_i,
  output evt_hot_t     hot_o
);
  always_comb begin
    hot_o      = '0;
    hot_o.done = done_i;
    if (done_i) begin
      case (kind_i)
        EVK_CHM:   hot_o.chm   = 1'b1;
        EVK_REI:   hot_o.rei   = 1'b1;
        EVK_SET_T: hot_o.set_t = 1'b1;
        EVK_CALL:  hot_o.call  = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/tpc_bits.sv
module tpc_bits
  import tpc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  evt_hot_t hot_i,
  input  logic     rei_t_i,
  input  logic     rei_tp_i,
  output logic     t_q,
  output logic     tp_q
);
  logic t_n, tp_n;

  always_comb begin
    t_n  = t_q;
    tp_n = tp_q;
    if (start_i && tp_q) tp_n = 1'b0;
    if (hot_i.done) begin
      tp_n = t_q;
      if (hot_i.chm) begin
        t_n  = 1'b0;
        tp_n = 1'b0;
      end else if (hot_i.rei) begin
        t_n  = rei_t_i;
        tp_n = t_q | rei_tp_i;
      end else if (hot_i.set_t) begin
        t_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_q  <= 1'b0;
      tp_q <= 1'b0;
    end else begin
      t_q  <= t_n;
      tp_q <= tp_n;
    end
  end
endmodule

// File: rtl/tpc_save.sv
module tpc_save
  import tpc_pkg::*;
(
  input  evt_hot_t hot_i,
  input  logic     t_q,
  input  logic     tp_q,
  output logic     sav_t_o,
  output logic     sav_tp_o
);
  always_comb begin
    sav_t_o  = hot_i.call ? 1'b0 : t_q;
    sav_tp_o = hot_i.chm  ? t_q  : tp_q;
  end
endmodule

// File: rtl/tpc_trace_ctrl.sv
module tpc_trace_ctrl
  import tpc_pkg::*;
#(
  parameter int EVT_W = KIND_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inst_start,
  input  logic             inst_done,
  input  logic [EVT_W-1:0] evt_kind,
  input  logic             rei_t,
  input  logic             rei_tp,
  input  logic             rsvd_opc,
  output logic             trace_req,
  output logic             rsvd_fault,
  output logic             t_live,
  output logic             tp_live,
  output logic             sav_t,
  output logic             sav_tp
);
  evt_hot_t hot;

  tpc_evt_decode #(.W(EVT_W)) u_dec (
    .done_i(inst_done), .kind_i(evt_kind), .hot_o(hot)
  );

  tpc_bits u_bits (
    .clk(clk), .rst_n(rst_n), .start_i(inst_start), .hot_i(hot),
    .rei_t_i(rei_t), .rei_tp_i(rei_tp), .t_q(t_live), .tp_q(tp_live)
  );

  tpc_save u_save (
    .hot_i(hot), .t_q(t_live), .tp_q(tp_live),
    .sav_t_o(sav_t), .sav_tp_o(sav_tp)
  );

  // Trace check comes first; other start-time faults wait for the restart.
  assign trace_req  = inst_start & tp_live;
  assign rsvd_fault = inst_start & rsvd_opc & ~tp_live;
endmodule

// File: rtl/tpc_trace_ctrl_chk.sv
module tpc_trace_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       inst_start,
  input logic       inst_done,
  input logic [2:0] evt_kind,
  input logic       rei_t,
  input logic       rei_tp,
  input logic       rsvd_opc,
  input logic       trace_req,
  input logic       rsvd_fault,
  input logic       t_live,
  input logic       tp_live,
  input logic       sav_t,
  input logic       sav_tp
);
  // R10
  req_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trace_req |-> inst_start);
  // R2
  tp_clears_on_trace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_req && !inst_done) |=> !tp_live);
  // R3
  trace_beats_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trace_req && rsvd_fault));
  // R5
  chm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_done && evt_kind == 3'd1) |=> (!t_live && !tp_live));
  // R6
  rei_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_done && evt_kind == 3'd2 && (t_live || rei_tp)) |=> tp_live);
  // R7
  set_t_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_done && evt_kind == 3'd3 && !t_live) |=> (t_live && !tp_live));
  // R8
  call_saves_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_done && evt_kind == 3'd4) |-> !sav_t);
  // R8
  call_keeps_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_done && evt_kind == 3'd4) |=> (t_live == $past(t_live)));
endmodule

bind tpc_trace_ctrl tpc_trace_ctrl_chk u_chk (.*);

// File: tb/test_tpc_trace_ctrl.sv
`timescale 1ns/1ps
module test_tpc_trace_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inst_start = 1'b0, inst_done = 1'b0;
  logic [2:0] evt_kind = 3'd0;
  logic       rei_t = 1'b0, rei_tp = 1'b0, rsvd_opc = 1'b0;
  logic       trace_req, rsvd_fault, t_live, tp_live, sav_t, sav_tp;

  int checks = 0;
  int errors = 0;
  bit mt = 1'b0, mtp = 1'b0;

  typedef struct {
    bit    trace;
    bit    rsvd;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  tpc_trace_ctrl i_tpc_trace_ctrl (
    .clk(clk), .rst_n(rst_n), .inst_start(inst_start), .inst_done(inst_done),
    .evt_kind(evt_kind), .rei_t(rei_t), .rei_tp(rei_tp), .rsvd_opc(rsvd_opc),
    .trace_req(trace_req), .rsvd_fault(rsvd_fault), .t_live(t_live),
    .tp_live(tp_live), .sav_t(sav_t), .sav_tp(sav_tp)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Monitor: on every start cycle, pop and compare the expected requests.
  always @(negedge clk) begin
    if (rst_n && inst_start) begin
      if (q.size() == 0) begin
        chk("R2 unexpected start", 1'b1, 1'b0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " trace_req"}, trace_req, e.trace);
        chk({e.tag, " rsvd_fault"}, rsvd_fault, e.rsvd);
      end
    end
  end

  // Driver: one instruction, with a restart after a taken trace.
  task automatic instr(logic [2:0] kind, bit rt, bit rtp, bit rsvd, string tag);
    bit old_t;
    @(posedge clk); #1;
    inst_start = 1'b1; rsvd_opc = rsvd;
    q.push_back('{mtp, rsvd & ~mtp, {tag, " R2/R3 start"}});
    if (mtp) begin
      mtp = 1'b0;
      @(posedge clk); #1;
      q.push_back('{1'b0, rsvd, {tag, " R3 restart"}});
    end
    @(posedge clk); #1;
    inst_start = 1'b0; rsvd_opc = 1'b0;
    inst_done = 1'b1; evt_kind = kind; rei_t = rt; rei_tp = rtp;
    #1;
    old_t = mt;
    if (kind == 3'd1) begin
      chk({tag, " R5 sav_t"}, sav_t, old_t);
      chk({tag, " R5 sav_tp"}, sav_tp, old_t);
    end else if (kind == 3'd4) begin
      chk({tag, " R8 sav_t"}, sav_t, 1'b0);
    end else begin
      chk({tag, " R11 sav_t"}, sav_t, mt);
      chk({tag, " R11 sav_tp"}, sav_tp, mtp);
    end
    case (kind)
      3'd1:    begin mt = 1'b0; mtp = 1'b0; end
      3'd2:    begin mtp = old_t | rtp; mt = rt; end
      3'd3:    begin mtp = old_t; mt = 1'b1; end
      default: mtp = old_t;
    endcase
    @(posedge clk); #1;
    inst_done = 1'b0; evt_kind = 3'd0; rei_t = 1'b0; rei_tp = 1'b0;
    chk({tag, " t_live"}, t_live, mt);
    chk({tag, " tp_live"}, tp_live, mtp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk("R1 t_live", t_live, 1'b0);
    chk("R1 tp_live", tp_live, 1'b0);
    chk("R1 trace_req", trace_req, 1'b0);
    rst_n = 1'b1;
    instr(3'd0, 0, 0, 0, "R4 plain untraced");
    instr(3'd3, 0, 0, 0, "R7 set enable");
    instr(3'd0, 0, 0, 0, "R7 first after set");
    // R10: pending set, idle cycles without start
    @(posedge clk); #1;
    chk("R10 idle trace_req", trace_req, 1'b0);
    chk("R10 idle tp_live", tp_live, 1'b1);
    instr(3'd0, 0, 0, 1, "R7 second after set, reserved opc");
    instr(3'd4, 0, 0, 0, "R8 call traced");
    instr(3'd7, 0, 0, 0, "R9 code 7");
    instr(3'd1, 0, 0, 0, "R5 mode change traced");
    instr(3'd0, 0, 0, 0, "R4 after mode change");
    instr(3'd2, 0, 1, 0, "R6 rei restored pending");
    instr(3'd5, 0, 0, 0, "R9 code 5");
    instr(3'd2, 1, 0, 0, "R6 rei restored enable");
    instr(3'd0, 0, 0, 0, "R6 first after rei");
    instr(3'd2, 0, 0, 0, "R6 rei old enable");
    instr(3'd6, 0, 0, 1, "R9 code 6 reserved opc");
    instr(3'd2, 0, 0, 0, "R6 rei nothing");
    instr(3'd0, 0, 0, 0, "R4 final untraced");
    repeat (2) @(posedge clk);
    chk("R2 queue drained", q.size() == 0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule